// File: doc/BRIEF.md
# Coefficient Dequantizer

This unit sits between a run-length coefficient decoder and an 8x8 inverse transform. It accepts one 16-bit packed word per handshake. Each word carries a signed 10-bit coefficient value in its low bits and, for all but the first word of a block, a 6-bit count of skipped zero coefficients in its upper bits. Alongside each word it takes a quantizer value and a flag that marks the block's first (DC) word.

Each coefficient is scaled by the quantizer using a fixed-point rule. The DC and the other (AC) coefficients use different shifts. A nonzero quantizer adds a rounding bias of 8 toward zero. A zero quantizer takes a separate doubling path. The result is clamped to the signed 16-bit range.

The unit outputs the scaled value together with its zigzag position in the block. It keeps track of that position so that skipped zeros are accounted for. A reserved end-of-block word resets the position and raises a one-cycle completion pulse. The unit has one output register and sustains one coefficient per clock when the consumer is ready.

Top module: `coef_dequant`

## Requirements
- R1: The coefficient is bits [9:0] of `in_word`, read as a two's-complement value (bit 9 is the sign). For a word flagged as first, bits [15:10] are ignored.
- R2: For a first word with a nonzero quantizer q, the raw result is coef*q*16.
- R3: For a non-first word with a nonzero q, the raw result is ((coef*q) arithmetically shifted right by 3)*16.
- R4: With a nonzero q, 8 is added to the raw result when coef is negative and 8 is subtracted when coef is positive. Nothing is added when coef is zero.
- R5: When q is zero, the result is coef*32, with no bias, for both first and non-first words.
- R6: The result is clamped to [-32768, 32767] before it appears on `out_coef`.
- R7: A first word gets position 0. A non-first word gets the position (previous output position + 1 + bits [15:10]) modulo 64. After reset, or after an end marker, the previous position is taken as -1.
- R8: A non-first word equal to 0xFE00 is an end marker. It produces no coefficient, `block_done` is high for exactly the one cycle after it is accepted, and the next non-first word is placed as if it began a new block. A word of 0xFE00 flagged as first is an ordinary DC coefficient (-512).
- R9: A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being consumed. The result appears on `out_*` in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold steady. Back-to-back words flow at one per cycle.
- R10: After reset, `out_valid` and `block_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit can accept a word |
| in_word | input | 16 | Packed run/coefficient word |
| in_q | input | 6 | Quantizer for this word |
| in_first | input | 1 | Word is the block's DC coefficient |
| out_valid | output | 1 | Output coefficient valid |
| out_ready | input | 1 | Consumer takes the output |
| out_coef | output | 16 | Scaled signed coefficient |
| out_pos | output | 6 | Zigzag position of the coefficient |
| block_done | output | 1 | One-cycle pulse after an end marker |

## Verification
The scaling path is tested with coefficients that are positive, negative and zero, under small, large and zero quantizers. The same value is also sent once as DC and once as AC, which separates the DC shift rule from the AC truncate-then-shift rule. Values of -1 and -7 with q=1 show that the AC shift rounds toward negative infinity before the bias is applied. The largest magnitudes against the top quantizer exercise both clamp limits. Run counts of 0, 2 and 63 exercise position tracking and wrap-around. End markers are sent both unflagged and flagged as first, to check that the marker is recognised only when the first flag is low. A stalled consumer with a pending word confirms that the output holds and that acceptance waits.

// File: rtl/coef_dequant.sv
module coef_dequant #(
  parameter int          WORD_W   = 16,
  parameter int          CW       = 10,
  parameter int          QW       = 6,
  parameter int          OW       = 16,
  parameter logic [15:0] EOB_WORD = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [QW-1:0]     in_q,
  input  logic              in_first,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OW-1:0]     out_coef,
  output logic [WORD_W-CW-1:0] out_pos,
  output logic              block_done
);
  localparam int PW  = WORD_W - CW;
  localparam int PRW = CW + QW + 1;
  localparam int SW  = PRW + 6;
  localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};
  localparam logic signed [SW-1:0] BIAS = SW'(8);

  logic                  acc, is_eob;
  logic signed [CW-1:0]  coef;
  logic [PW-1:0]         run, pos_next, cur_pos;
  logic signed [PRW-1:0] prod;
  logic signed [SW-1:0]  coef_x, prod_x, base, scaled;
  logic [OW-1:0]         sat;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign is_eob   = !in_first && (in_word == EOB_WORD);
  assign coef     = $signed(in_word[CW-1:0]);
  assign run      = in_word[WORD_W-1:CW];
  assign cur_pos  = in_first ? '0 : pos_next + run;
  assign prod     = $signed({{(QW+1){coef[CW-1]}}, coef}) * $signed({{CW{1'b0}}, 1'b0, in_q});
  assign coef_x   = $signed({{(SW-CW){coef[CW-1]}}, coef});
  assign prod_x   = $signed({{(SW-PRW){prod[PRW-1]}}, prod});

  always_comb begin
    if (in_q == '0)    base = coef_x <<< 5;
    else if (in_first) base = prod_x <<< 4;
    else               base = (prod_x >>> 3) <<< 4;
    scaled = base;
    if (in_q != '0) begin
      if (coef < 0)       scaled = base + BIAS;
      else if (coef != 0) scaled = base - BIAS;
    end
    if (scaled > MAXV)      sat = MAXV[OW-1:0];
    else if (scaled < MINV) sat = MINV[OW-1:0];
    else                    sat = scaled[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_coef   <= '0;
      out_pos    <= '0;
      pos_next   <= '0;
      block_done <= 1'b0;
    end else begin
      block_done <= acc && is_eob;
      if (acc) begin
        if (is_eob) begin
          out_valid <= 1'b0;
          pos_next  <= '0;
        end else begin
          out_valid <= 1'b1;
          out_coef  <= sat;
          out_pos   <= cur_pos;
          pos_next  <= cur_pos + 1'b1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module coef_dequant_chk #(
  parameter logic [15:0] EOB_WORD = 16'hFE00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word,
  input logic        in_first,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_coef,
  input logic [5:0]  out_pos,
  input logic        block_done
);
  logic take, eob;
  assign take = in_valid && in_ready;
  assign eob  = !in_first && (in_word == EOB_WORD);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coef) && $stable(out_pos));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !eob |=> out_valid);
  assert_dc_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_first |=> out_pos == 6'd0);
  assert_eob_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && eob |=> block_done && !out_valid);
  assert_done_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> $past(take && eob));
endmodule

bind coef_dequant coef_dequant_chk #(.EOB_WORD(EOB_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .in_first(in_first), .out_valid(out_valid),
  .out_ready(out_ready), .out_coef(out_coef), .out_pos(out_pos),
  .block_done(block_done)
);

// File: tb/tb_coef_dequant.sv
module tb_coef_dequant;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b1;
  logic [15:0] in_word = '0;
  logic [5:0]  in_q = '0;
  logic        in_ready, out_valid, block_done;
  logic [15:0] out_coef;
  logic [5:0]  out_pos;
  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  coef_dequant dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_q(in_q), .in_first(in_first),
    .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef),
    .out_pos(out_pos), .block_done(block_done)
  );

  function automatic int model(logic [15:0] w, int q, bit dc);
    int c, r;
    c = int'($signed(w[9:0]));
    if (q == 0) r = c * 32;
    else begin
      r = c * q;
      if (!dc) r = r >>> 3;
      r = r * 16;
      if (c < 0) r = r + 8;
      else if (c > 0) r = r - 8;
    end
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w, logic [5:0] q, bit first);
    @(negedge clk);
    in_word = w; in_q = q; in_first = first; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_chk(string req, logic [15:0] w, logic [5:0] q, bit first, int pos);
    send(w, q, first);
    chk(req, int'(out_valid), 1);
    chk(req, int'($signed(out_coef)), model(w, int'(q), first));
    chk(req, int'(out_pos), pos);
  endtask

  task automatic t_reset;
    chk("R10", int'(out_valid), 0);
    chk("R10", int'(block_done), 0);
    chk("R10", int'(in_ready), 1);
  endtask

  task automatic t_dc;
    send_chk("R2", 16'h0005, 6'd4, 1, 0);
    chk("R2", int'($signed(out_coef)), 312);
    send_chk("R1", 16'hFC05, 6'd4, 1, 0);
    chk("R1", int'($signed(out_coef)), 312);
    send_chk("R4", 16'h0001, 6'd1, 1, 0);
    chk("R4", int'($signed(out_coef)), 8);
    send_chk("R1", 16'h03FD, 6'd2, 1, 0);
    chk("R1", int'($signed(out_coef)), -88);
  endtask

  task automatic t_ac;
    send_chk("R2", 16'h0000, 6'd3, 1, 0);
    send_chk("R3", 16'h0064, 6'd10, 0, 1);
    chk("R3", int'($signed(out_coef)), 1992);
    send_chk("R3", 16'h039C, 6'd10, 0, 2);
    chk("R3", int'($signed(out_coef)), -1992);
    send_chk("R4", 16'h0001, 6'd1, 0, 3);
    chk("R4", int'($signed(out_coef)), -8);
    send_chk("R4", 16'h03FF, 6'd1, 0, 4);
    chk("R4", int'($signed(out_coef)), -8);
    send_chk("R4", 16'h03F9, 6'd1, 0, 5);
    chk("R4", int'($signed(out_coef)), -8);
    send_chk("R4", 16'h0000, 6'd9, 0, 6);
    chk("R4", int'($signed(out_coef)), 0);
  endtask

  task automatic t_zero_q;
    send_chk("R5", 16'h03FD, 6'd0, 1, 0);
    chk("R5", int'($signed(out_coef)), -96);
    send_chk("R5", 16'h0007, 6'd0, 0, 1);
    chk("R5", int'($signed(out_coef)), 224);
  endtask

  task automatic t_sat;
    send_chk("R6", 16'h01FF, 6'd63, 1, 0);
    chk("R6", int'($signed(out_coef)), 32767);
    send_chk("R6", 16'h0200, 6'd63, 0, 1);
    chk("R6", int'($signed(out_coef)), -32768);
    send_chk("R6", 16'h01FF, 6'd63, 0, 2);
    chk("R6", int'($signed(out_coef)), 32767);
  endtask

  task automatic t_pos;
    send_chk("R7", 16'h0010, 6'd2, 1, 0);
    send_chk("R7", 16'h0803, 6'd2, 0, 3);
    send_chk("R7", 16'h0003, 6'd2, 0, 4);
    send_chk("R7", 16'hFC03, 6'd2, 0, 4);
  endtask

  task automatic t_eob;
    send_chk("R8", 16'h0011, 6'd2, 1, 0);
    send_chk("R8", 16'h0811, 6'd2, 0, 3);
    send(16'hFE00, 6'd2, 0);
    chk("R8", int'(out_valid), 0);
    chk("R8", int'(block_done), 1);
    @(posedge clk); #1;
    chk("R8", int'(block_done), 0);
    send_chk("R8", 16'h0004, 6'd2, 0, 0);
    send_chk("R8", 16'hFE00, 6'd2, 1, 0);
    chk("R8", int'($signed(out_coef)), -16376);
    chk("R8", int'(block_done), 0);
  endtask

  task automatic t_stall;
    repeat (2) @(negedge clk);
    out_ready = 1'b0;
    send_chk("R9", 16'h0021, 6'd5, 1, 0);
    @(negedge clk);
    in_word = 16'h0422; in_q = 6'd5; in_first = 1'b0; in_valid = 1'b1;
    #1 chk("R9", int'(in_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R9", int'(out_valid), 1);
      chk("R9", int'($signed(out_coef)), model(16'h0021, 5, 1));
      chk("R9", int'(out_pos), 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9", int'(out_valid), 1);
    chk("R9", int'($signed(out_coef)), model(16'h0422, 5, 0));
    chk("R9", int'(out_pos), 2);
  endtask

  task automatic t_stream;
    logic [15:0] w;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      w = 16'(i * 37 + 3) & 16'h03FF;
      in_word = w; in_q = 6'(i + 1); in_first = (i == 0); in_valid = 1'b1;
      @(posedge clk); #1;
      chk("R9", int'(out_valid), 1);
      chk("R9", int'($signed(out_coef)), model(w, i + 1, i == 0));
      chk("R9", int'(out_pos), i);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_dc();
    t_ac();
    t_zero_q();
    t_sat();
    t_pos();
    t_eob();
    t_stall();
    t_stream();
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule